// File: doc/BRIEF.md
# Byte-Accessed Free-Running Timer with Read Snapshot

This block is a 16-bit up-counter that a processor reaches over an 8-bit register bus. The counter advances once for every prescaled tick that arrives while counting is enabled. It wraps to zero, and each wrap sets a sticky overflow flag that drives an interrupt line. Software can only move one byte per access. A carry between the two byte reads could therefore tear the value. To prevent this, reading the low byte copies the counter's upper byte into a snapshot register in the same cycle. A later read of the upper-byte address returns that snapshot and not the live byte.

Loading works the same way in reverse. A write to the upper-byte address lands in a staging buffer. The following low-byte write moves all sixteen bits into the counter at once. Every low-byte read refreshes the snapshot, including a read that another reader slips in between someone else's low and high reads. Software that can be pre-empted between its two reads must still guard the pair.

A byte-mode input turns the block into an 8-bit timer. In this mode a single low-byte read is already atomic.

Top module: `tmr16_shadow`

## Requirements
- R1: With `cnt_en` high and `tick` high in a cycle with no low-byte write, the count rises by one at that clock edge and wraps from 0xFFFF to 0x0000 in 16-bit mode.
- R2: While `cnt_en` is low, ticks are ignored: the count holds and the overflow flag is not set.
- R3: A counting step that wraps the count sets a sticky overflow flag. `ovf_irq` shows the flag one cycle after the wrapping edge, and it stays high until cleared.
- R4: A bus write to address 2 with data bit 0 set clears the flag. If a wrap happens in the same cycle, the flag stays set. Writes with bit 0 clear leave the flag unchanged.
- R5: A bus read of address 0 returns the counter's low byte on `bus_rdata` in the next cycle. In the same cycle, the counter's upper byte is copied into the snapshot register.
- R6: A bus read of address 1 returns the snapshot register, never the live upper byte.
- R7: Every read of address 0 refreshes the snapshot. A read of address 1 after two address-0 reads returns the upper byte as it stood at the second of those reads.
- R8: A write to address 1 fills the staging buffer. A write to address 0 loads {staging buffer, data} into the counter at that edge, and it takes precedence over a tick in the same cycle.
- R9: While `byte_mode` is high, the counter's upper byte is held at zero. The low byte counts from 0xFF to 0x00 and sets the overflow flag on that wrap. A low-byte write loads {0x00, data}.
- R10: A synchronous `rst` clears the count, the snapshot, the staging buffer, the flag and `bus_rdata`.
- R11: `bus_rdata` is registered and holds between reads. A read of address 2 returns the flag in bit 0 and zeros elsewhere. A read of address 3 returns zero, and writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counting enable |
| tick | input | 1 | Prescaled count strobe |
| byte_mode | input | 1 | Run as an 8-bit timer |
| bus_addr | input | 2 | Register select: 0 low byte, 1 high byte, 2 status |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ovf_irq | output | 1 | Sticky overflow flag |

## Verification
A corrupted count shows up on the very next address-0 read, one cycle after the strobe. It also distorts the cycle on which `ovf_irq` rises after a wrap. A stale or wrongly refreshed snapshot is visible only on an address-1 read: it shows as a high byte that disagrees with the preceding low-byte read. The bench provokes this directly by ticking across a carry between the two reads, and by interleaving two low-byte reads. A staging-buffer fault stays hidden until the next low-byte write, and it then shows as a wrong high byte on the following read pair.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  localparam int unsigned SEL_LO   = 0;
  localparam int unsigned SEL_HI   = 1;
  localparam int unsigned SEL_STAT = 2;

  typedef struct packed {
    logic rd_lo;
    logic rd_hi;
    logic rd_stat;
    logic rd_other;
    logic wr_lo;
    logic wr_hi;
    logic wr_clr;
  } bus_req_t;

endpackage

// File: rtl/tmr16_decode.sv
module tmr16_decode
  import tmr16_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output bus_req_t          req
);

  logic hit_lo, hit_hi, hit_stat;

  always_comb begin
    hit_lo   = (bus_addr == ADDR_W'(SEL_LO));
    hit_hi   = (bus_addr == ADDR_W'(SEL_HI));
    hit_stat = (bus_addr == ADDR_W'(SEL_STAT));
    req.rd_lo    = bus_rd & hit_lo;
    req.rd_hi    = bus_rd & hit_hi;
    req.rd_stat  = bus_rd & hit_stat;
    req.rd_other = bus_rd & ~(hit_lo | hit_hi | hit_stat);
    req.wr_lo    = bus_wr & hit_lo;
    req.wr_hi    = bus_wr & hit_hi;
    req.wr_clr   = bus_wr & hit_stat & bus_wdata[0];
  end

endmodule

// File: rtl/tmr16_count.sv
module tmr16_count #(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              tick,
  input  logic              byte_mode,
  input  logic              load,
  input  logic [DATA_W-1:0] load_hi,
  input  logic [DATA_W-1:0] load_lo,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              ovf_pulse
);

  logic [CNT_W-1:0]  cnt_d;
  logic [DATA_W-1:0] lo_inc;
  logic              step;
  logic              wrap_lo, wrap_all;

  always_comb begin
    step     = cnt_en & tick & ~load;
    lo_inc   = cnt_q[DATA_W-1:0] + 1'b1;
    wrap_lo  = &cnt_q[DATA_W-1:0];
    wrap_all = &cnt_q;
    cnt_d    = cnt_q;
    if (load) begin
      cnt_d = byte_mode ? {{DATA_W{1'b0}}, load_lo} : {load_hi, load_lo};
    end else if (step) begin
      cnt_d = byte_mode ? {{DATA_W{1'b0}}, lo_inc} : cnt_q + 1'b1;
    end else if (byte_mode) begin
      cnt_d[CNT_W-1:DATA_W] = '0;
    end
    ovf_pulse = step & (byte_mode ? wrap_lo : wrap_all);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

endmodule

// File: rtl/tmr16_byteport.sv
module tmr16_byteport
  import tmr16_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_req_t          req,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              flag_q,
  output logic [DATA_W-1:0] shadow_q,
  output logic [DATA_W-1:0] wbuf_q,
  output logic [DATA_W-1:0] rdata_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      wbuf_q   <= '0;
    end else begin
      if (req.rd_lo) shadow_q <= cnt_q[CNT_W-1:DATA_W];
      if (req.wr_hi) wbuf_q   <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               rdata_q <= '0;
    else if (req.rd_lo)    rdata_q <= cnt_q[DATA_W-1:0];
    else if (req.rd_hi)    rdata_q <= shadow_q;
    else if (req.rd_stat)  rdata_q <= {{(DATA_W-1){1'b0}}, flag_q};
    else if (req.rd_other) rdata_q <= '0;
  end

endmodule

// File: rtl/tmr16_flag.sv
module tmr16_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_pulse,
  input  logic clr_req,
  output logic flag_q
);

  always_ff @(posedge clk) begin
    if (rst)            flag_q <= 1'b0;
    else if (set_pulse) flag_q <= 1'b1;
    else if (clr_req)   flag_q <= 1'b0;
  end

endmodule

// File: rtl/tmr16_shadow.sv
module tmr16_shadow
  import tmr16_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              tick,
  input  logic              byte_mode,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ovf_irq
);

  localparam int CNT_W = 2 * DATA_W;

  bus_req_t          req;
  logic [CNT_W-1:0]  cnt_val;
  logic [DATA_W-1:0] shadow_val;
  logic [DATA_W-1:0] wbuf_val;
  logic              ovf_pulse;
  logic              flag_val;

  tmr16_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .req       (req)
  );

  tmr16_count #(.DATA_W(DATA_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .cnt_en    (cnt_en),
    .tick      (tick),
    .byte_mode (byte_mode),
    .load      (req.wr_lo),
    .load_hi   (wbuf_val),
    .load_lo   (bus_wdata),
    .cnt_q     (cnt_val),
    .ovf_pulse (ovf_pulse)
  );

  tmr16_byteport #(.DATA_W(DATA_W)) u_port (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .bus_wdata (bus_wdata),
    .cnt_q     (cnt_val),
    .flag_q    (flag_val),
    .shadow_q  (shadow_val),
    .wbuf_q    (wbuf_val),
    .rdata_q   (bus_rdata)
  );

  tmr16_flag u_flag (
    .clk       (clk),
    .rst       (rst),
    .set_pulse (ovf_pulse),
    .clr_req   (req.wr_clr),
    .flag_q    (flag_val)
  );

  assign ovf_irq = flag_val;

endmodule

// File: rtl/tmr16_shadow_chk.sv
module tmr16_shadow_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cnt_en,
  input logic              tick,
  input logic              byte_mode,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              ovf_irq,
  input logic [CNT_W-1:0]  cnt_val,
  input logic [DATA_W-1:0] shadow_val,
  input logic [DATA_W-1:0] wbuf_val
);

  logic wr_lo_c, rd_lo_c, rd_hi_c, clr_c;
  assign wr_lo_c = bus_wr && bus_addr == ADDR_W'(0);
  assign rd_lo_c = bus_rd && bus_addr == ADDR_W'(0);
  assign rd_hi_c = bus_rd && bus_addr == ADDR_W'(1);
  assign clr_c   = bus_wr && bus_addr == ADDR_W'(2) && bus_wdata[0];

  assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && tick && !wr_lo_c && !byte_mode) |=> cnt_val == $past(cnt_val) + 1'b1);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !wr_lo_c && !byte_mode) |=> cnt_val == $past(cnt_val));

  assert_no_ovf_when_off_R2: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !ovf_irq) |=> !ovf_irq);

  assert_ovf_set_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && tick && !wr_lo_c && !byte_mode && &cnt_val) |=> ovf_irq);

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (ovf_irq && !clr_c) |=> ovf_irq);

  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_c && !(cnt_en && tick && !wr_lo_c && &cnt_val[DATA_W-1:0])) |=> !ovf_irq);

  assert_snapshot_R5: assert property (@(posedge clk) disable iff (rst)
    rd_lo_c |=> shadow_val == $past(cnt_val[CNT_W-1:DATA_W]));

  assert_hi_read_R6: assert property (@(posedge clk) disable iff (rst)
    rd_hi_c |=> bus_rdata == $past(shadow_val));

  assert_load_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_lo_c && !byte_mode) |=> cnt_val == {$past(wbuf_val), $past(bus_wdata)});

  assert_byte_hi_zero_R9: assert property (@(posedge clk) disable iff (rst)
    byte_mode |=> cnt_val[CNT_W-1:DATA_W] == '0);

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind tmr16_shadow tmr16_shadow_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cnt_en     (cnt_en),
  .tick       (tick),
  .byte_mode  (byte_mode),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .ovf_irq    (ovf_irq),
  .cnt_val    (cnt_val),
  .shadow_val (shadow_val),
  .wbuf_val   (wbuf_val)
);

// File: tb/sim_tmr16_shadow.sv
`timescale 1ns/1ps
module sim_tmr16_shadow;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0, tick = 1'b0, byte_mode = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ovf_irq;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  // reference state
  logic [15:0] m_cnt = '0;
  logic [7:0]  m_sh = '0, m_wb = '0, m_rd = '0;
  logic        m_flag = 1'b0;

  always #4 clk = ~clk;

  tmr16_shadow u0 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .tick(tick), .byte_mode(byte_mode),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_irq(ovf_irq)
  );

  function automatic logic [15:0] f_next_cnt(logic [15:0] c, logic en, logic tk,
      logic m8, logic ld, logic [7:0] wb, logic [7:0] d);
    if (ld)            return m8 ? {8'h00, d} : {wb, d};
    else if (en && tk) return m8 ? {8'h00, c[7:0] + 8'h01} : c + 16'h0001;
    else               return m8 ? {8'h00, c[7:0]} : c;
  endfunction

  function automatic logic f_wrap(logic [15:0] c, logic en, logic tk, logic m8, logic ld);
    return !ld && en && tk && (m8 ? (c[7:0] == 8'hFF) : (c == 16'hFFFF));
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one bus cycle; reference updated on the edge; outputs compared 1 ns later
  task automatic step(input logic rd, input logic wr, input logic [1:0] a,
                      input logic [7:0] d, input logic tk);
    logic ld, wrp;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d; tick = tk;
    @(posedge clk);
    ld  = wr && a == 2'd0;
    wrp = f_wrap(m_cnt, cnt_en, tk, byte_mode, ld);
    if (rd) begin
      case (a)
        2'd0: m_rd = m_cnt[7:0];
        2'd1: m_rd = m_sh;
        2'd2: m_rd = {7'b0, m_flag};
        default: m_rd = 8'h00;
      endcase
    end
    if (rd && a == 2'd0) m_sh = m_cnt[15:8];
    if (wrp) m_flag = 1'b1;
    else if (wr && a == 2'd2 && d[0]) m_flag = 1'b0;
    m_cnt = f_next_cnt(m_cnt, cnt_en, tk, byte_mode, ld, m_wb, d);
    if (wr && a == 2'd1) m_wb = d;
    #1;
    check("R11 rdata", {8'h00, bus_rdata}, {8'h00, m_rd});
    check("R3 ovf_irq", {15'h0, ovf_irq}, {15'h0, m_flag});
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    step(1'b1, 1'b0, a, 8'h00, 1'b0);
    v = bus_rdata;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    step(1'b0, 1'b1, a, d, 1'b0);
  endtask

  task automatic load16(input logic [15:0] v);
    wr_reg(2'd1, v[15:8]);
    wr_reg(2'd0, v[7:0]);
  endtask

  initial begin
    logic [7:0] lo, hi;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R10: reset state
    check("R10 rdata after reset", {8'h00, bus_rdata}, 16'h0000);
    check("R10 ovf after reset", {15'h0, ovf_irq}, 16'h0000);
    rd_reg(2'd0, lo); rd_reg(2'd1, hi);
    check("R10 count after reset", {hi, lo}, 16'h0000);

    // R8: staged load
    load16(16'h1234);
    rd_reg(2'd0, lo); rd_reg(2'd1, hi);
    check("R8 load", {hi, lo}, 16'h1234);

    // R8: load beats tick
    cnt_en = 1'b1;
    wr_reg(2'd1, 8'h20);
    step(1'b0, 1'b1, 2'd0, 8'h50, 1'b1);
    rd_reg(2'd0, lo); rd_reg(2'd1, hi);
    check("R8 load over tick", {hi, lo}, 16'h2050);

    // R1: counting
    repeat (3) step(1'b0, 1'b0, 2'd0, 8'h00, 1'b1);
    rd_reg(2'd0, lo);
    check("R1 three ticks", {8'h00, lo}, 16'h0053);

    // R2: enable low ignores ticks
    cnt_en = 1'b0;
    load16(16'hFFFF);
    repeat (5) step(1'b0, 1'b0, 2'd0, 8'h00, 1'b1);
    check("R2 no ovf while off", {15'h0, ovf_irq}, 16'h0000);
    rd_reg(2'd0, lo); rd_reg(2'd1, hi);
    check("R2 held", {hi, lo}, 16'hFFFF);

    // R3: wrap sets sticky flag
    cnt_en = 1'b1;
    step(1'b0, 1'b0, 2'd0, 8'h00, 1'b1);
    check("R3 flag set", {15'h0, ovf_irq}, 16'h0001);
    rd_reg(2'd0, lo); rd_reg(2'd1, hi);
    check("R1 wrap to zero", {hi, lo}, 16'h0000);
    wr_reg(2'd2, 8'h00);
    check("R4 bit0 clear keeps flag", {15'h0, ovf_irq}, 16'h0001);
    rd_reg(2'd2, lo);
    check("R11 status read", {8'h00, lo}, 16'h0001);

    // R4: clear, then clear racing a wrap
    wr_reg(2'd2, 8'h01);
    check("R4 cleared", {15'h0, ovf_irq}, 16'h0000);
    load16(16'hFFFF);
    step(1'b0, 1'b1, 2'd2, 8'h01, 1'b1);
    check("R4 overflow wins", {15'h0, ovf_irq}, 16'h0001);
    wr_reg(2'd2, 8'h01);

    // R6: high read returns snapshot across a carry
    load16(16'h00FF);
    rd_reg(2'd0, lo);
    step(1'b0, 1'b0, 2'd0, 8'h00, 1'b1);
    rd_reg(2'd1, hi);
    check("R6 snapshot not live", {hi, lo}, 16'h00FF);

    // R7: interleaved low read refreshes snapshot
    load16(16'h01FF);
    rd_reg(2'd0, lo);
    step(1'b0, 1'b0, 2'd0, 8'h00, 1'b1);
    rd_reg(2'd0, hi);
    rd_reg(2'd1, hi);
    check("R7 refreshed snapshot", {hi, lo}, 16'h02FF);

    // R11: address 3 reads zero, writes ignored
    wr_reg(2'd3, 8'hFF);
    rd_reg(2'd3, lo);
    check("R11 addr3 zero", {8'h00, lo}, 16'h0000);
    check("R11 addr3 write no flag", {15'h0, ovf_irq}, 16'h0000);

    // R9: byte mode
    byte_mode = 1'b1;
    wr_reg(2'd1, 8'h77);
    wr_reg(2'd0, 8'hFE);
    step(1'b0, 1'b0, 2'd0, 8'h00, 1'b1);
    check("R9 no ovf at FF", {15'h0, ovf_irq}, 16'h0000);
    step(1'b0, 1'b0, 2'd0, 8'h00, 1'b1);
    check("R9 byte wrap flag", {15'h0, ovf_irq}, 16'h0001);
    rd_reg(2'd0, lo); rd_reg(2'd1, hi);
    check("R9 byte count", {hi, lo}, 16'h0000);
    byte_mode = 1'b0;
    wr_reg(2'd2, 8'h01);

    // random traffic against the reference
    void'($urandom(32'h5EED));
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      logic [7:0] d;
      r = $urandom;
      if ($urandom % 50 == 0) cnt_en = ~cnt_en;
      if ($urandom % 300 == 0) byte_mode = ~byte_mode;
      d = ($urandom % 2 == 0) ? 8'hFF : 8'($urandom);
      case (r % 8)
        0, 1, 2: step(1'b0, 1'b0, 2'd0, 8'h00, 1'($urandom));
        3, 7:    step(1'b1, 1'b0, 2'($urandom), 8'h00, 1'($urandom));
        4:       step(1'b0, 1'b1, 2'd1, d, 1'($urandom));
        5:       step(1'b0, 1'b1, 2'd0, d, 1'($urandom));
        default: step(1'b0, 1'b1, 2'($urandom), d, 1'($urandom));
      endcase
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule